// File: doc/BRIEF.md
# Extended-Precision Power-of-Two Scaler

This unit multiplies an 80-bit extended-precision value by two raised to a signed 32-bit integer. The value has a sign in bit 79, a 15-bit biased exponent in bits 78:64 and a 64-bit mantissa in bits 63:0, with an explicit integer bit at bit 63. The unit does no mantissa multiplication. It adds the integer to the exponent. When the exponent falls below zero, it shifts the mantissa right and rounds. When the exponent reaches the top code, it first normalizes unnormal mantissas and then saturates to infinity if the value is still too large. It normalizes denormals as far as the exponent allows, and it passes zero, infinity and NaN destinations through unchanged.

The scale value arrives already converted to an integer. A separate class input says what that scale operand was: a number, zero, infinity, quiet NaN or signaling NaN. A NaN or infinite scale operand replaces the result with a default NaN. Every operation produces condition flags, exception flags and a trap request. The trap request is the exception flags gated by a caller-supplied enable mask.

An operation starts with a one-cycle start pulse. The unit has a fixed two-cycle latency and does not accept a new operation while one is in flight.

Top module: `fx_scale_unit`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` is high for the cycle after acceptance. `done` pulses for exactly one cycle on the second rising edge after acceptance, and `result` and the flags hold their values until the next `done`. A `start` seen while `busy` is high is ignored.
- R2: A destination counts as a number when its exponent is between 1 and 0x7FFE, or when its exponent is 0 with a nonzero mantissa. For such a destination, the exponent sum (exponent plus signed scale) forms the result exponent whenever that sum stays in range and the integer bit is set. The mantissa and sign are unchanged in that case.
- R3: When the exponent sum is negative, the result exponent is 0 and the mantissa shifts right by the deficit (minus the sum). A deficit of 64 or more turns the whole mantissa into sticky bits. The inexact flag (exception bit 0) is set exactly when any shifted-out bit is 1.
- R4: Rounding on the negative-sum path uses `rnd_mode`. The codes are 0 = nearest-even, 1 = toward zero, 2 = toward minus infinity and 3 = toward plus infinity. The increment is one unit in the last place. In nearest mode it is added when the first lost bit is set and the other lost bits are nonzero; on an exact tie it is added only if the kept LSB is 1. The directed modes add it on any inexact result with a negative sign (code 2) or a positive sign (code 3).
- R5: After the negative-sum path, underflow (exception bit 1) is set when the result exponent is 0 and bit 63 is clear. In that case the zero condition (bit 2) is also set if the mantissa is all zero.
- R6: When the exponent sum is 0x7FFF or more, the mantissa is first shifted left by its leading-zero count, with the exponent reduced by the same amount. If the exponent is still 0x7FFF or more, the result is infinity (exponent 0x7FFF, mantissa 0) with overflow (exception bit 2) and the infinity condition (bit 1) set.
- R7: When the exponent sum is in range (0 to 0x7FFE) but bit 63 is clear, the mantissa shifts left by its leading-zero count, limited so the exponent stops at 0. If bit 63 is still clear afterwards, underflow is set.
- R8: The scale class codes are 0 = number, 1 = zero, 2 = infinity, 3 = quiet NaN and 4 = signaling NaN; codes 5 to 7 act as number. A scale class of 3 or 4 gives exponent 0x7FFF with an all-ones mantissa and the sign kept. Class 4 also sets the signaling-NaN exception (bit 4).
- R9: A scale class of 2 gives the same NaN pattern and sets the operand-error exception (bit 3) and the NaN condition (bit 0).
- R10: When the scale class is 0, 1 or 5 to 7, a destination that is zero, infinity or NaN is returned unchanged, with condition zero, infinity or NaN set respectively. A NaN destination with mantissa bit 62 clear also sets the signaling-NaN exception.
- R11: The negative condition (bit 3) always equals the result sign bit.
- R12: `trap` is high with `done` exactly when some exception flag of that operation is also set in `exc_enable`, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the operands presented |
| dst_op | input | 80 | Value to be scaled: sign, biased exponent, mantissa |
| scale | input | 32 | Signed power-of-two scale |
| src_class | input | 3 | Class of the scale operand |
| rnd_mode | input | 2 | Rounding mode for the underflow path |
| exc_enable | input | 5 | Per-exception trap enable mask |
| busy | output | 1 | Operation in flight; start is ignored |
| done | output | 1 | One-cycle pulse: result and flags updated |
| result | output | 80 | Scaled value |
| cond_flags | output | 4 | {neg, zero, inf, nan} |
| exc_flags | output | 5 | {snan, operr, ovfl, unfl, inex} |
| trap | output | 1 | Enabled exception raised |

## Verification
Every path settles in the single cycle after the operands are captured. A wrong exponent sum, a wrong shift amount or a wrong rounding choice therefore shows up in `result` and the flags at the very `done` pulse of the operation that caused it. Nothing carries over to later operations, so each vector fails on its own.

Errors in the mantissa show up in the low bits: a missed sticky bit, or a tie broken the wrong way, flips the result LSB or the inexact flag. The exponent-clamping corner cases show up as underflow or overflow flags that disagree with the result exponent. The deficit-of-64 boundary, the huge positive and negative scales, and the leading-zero limit against the exponent are each driven directly.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
  // scale operand classes
  typedef enum logic [2:0] {
    SRC_NUM  = 3'd0,
    SRC_ZERO = 3'd1,
    SRC_INF  = 3'd2,
    SRC_QNAN = 3'd3,
    SRC_SNAN = 3'd4
  } src_class_e;

  // rounding modes on the underflow path
  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_DOWN = 2'd2,
    RND_UP   = 2'd3
  } rnd_mode_e;

  // exception flag positions
  localparam int X_INEX  = 0;
  localparam int X_UNFL  = 1;
  localparam int X_OVFL  = 2;
  localparam int X_OPERR = 3;
  localparam int X_SNAN  = 4;
  localparam int X_W     = 5;

  // condition flag positions
  localparam int C_NAN  = 0;
  localparam int C_INF  = 1;
  localparam int C_ZERO = 2;
  localparam int C_NEG  = 3;
  localparam int C_W    = 4;
endpackage

// File: rtl/fxs_lzc.sv
module fxs_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // the highest set bit wins; an all-zero vector counts W
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fxs_lnorm.sv
module fxs_lnorm #(
  parameter int W  = 64,
  parameter int SW = 34,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]         mant,
  input  logic signed [SW-1:0] e_in,
  input  logic                 limit,
  output logic [W-1:0]         mant_out,
  output logic signed [SW-1:0] e_out
);
  logic [CW-1:0]         lz;
  logic signed [SW-1:0]  amt;

  fxs_lzc #(.W(W), .CW(CW)) u_lzc (
    .vec (mant),
    .cnt (lz)
  );

  // shift by the leading-zero count; optionally stop the exponent at 0
  always_comb begin
    amt = SW'(lz);
    if (limit && (e_in < amt)) amt = e_in;
    mant_out = mant << amt[CW-1:0];
    e_out    = e_in - amt;
  end
endmodule

// File: rtl/fxs_dn_round.sv
module fxs_dn_round
  import fxs_pkg::*;
#(
  parameter int W  = 64,
  parameter int SW = 34,
  localparam int DW = $clog2(W)
) (
  input  logic [W-1:0]  mant,
  input  logic [SW-1:0] deficit,
  input  logic          sign,
  input  logic [1:0]    mode,
  output logic [W-1:0]  mant_out,
  output logic          carry,
  output logic          inexact,
  output logic          round_up
);
  logic [2*W-1:0] wide;
  logic [W-1:0]   kept;
  logic           guard;
  logic           sticky;
  logic           far;
  logic [W:0]     sum;

  // W is a power of two, so a near deficit fits in DW bits
  always_comb begin
    far  = (deficit >= SW'(W));
    wide = {mant, {W{1'b0}}} >> deficit[DW-1:0];
    if (far) begin
      kept   = '0;
      guard  = 1'b0;
      sticky = |mant;
    end else begin
      kept   = wide[2*W-1:W];
      guard  = wide[W-1];
      sticky = |wide[W-2:0];
    end
    inexact = guard | sticky;
    case (rnd_mode_e'(mode))
      RND_NEAR: round_up = guard & (sticky | kept[0]);
      RND_ZERO: round_up = 1'b0;
      RND_DOWN: round_up = inexact & sign;
      default:  round_up = inexact & ~sign;
    endcase
    sum      = {1'b0, kept} + {{W{1'b0}}, round_up};
    carry    = sum[W];
    mant_out = carry ? {1'b1, {(W-1){1'b0}}} : sum[W-1:0];
  end

  // an increment is only ever taken on an inexact result (R4)
  always_comb begin
    p_rnd_needs_inexact_r4: assert (!round_up || inexact);
  end
endmodule

// File: rtl/fx_scale_unit.sv
module fx_scale_unit
  import fxs_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  parameter int SCL_W = 32,
  localparam int OP_W  = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OP_W-1:0]  dst_op,
  input  logic [SCL_W-1:0] scale,
  input  logic [2:0]       src_class,
  input  logic [1:0]       rnd_mode,
  input  logic [X_W-1:0]   exc_enable,
  output logic             busy,
  output logic             done,
  output logic [OP_W-1:0]  result,
  output logic [C_W-1:0]   cond_flags,
  output logic [X_W-1:0]   exc_flags,
  output logic             trap
);
  localparam int SUM_W = SCL_W + 2;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};
  localparam logic signed [SUM_W-1:0] SUM_TOP =
    {{(SUM_W-EXP_W){1'b0}}, {EXP_W{1'b1}}};

  // ---------------- stage 1: capture and exponent sum ----------------
  logic                    s1_vld;
  logic                    s1_sign;
  logic [EXP_W-1:0]        s1_exp;
  logic [MAN_W-1:0]        s1_man;
  logic signed [SUM_W-1:0] s1_sum;
  src_class_e              s1_cls;
  logic [1:0]              s1_rnd;
  logic [X_W-1:0]          s1_msk;
  logic                    accept;
  logic signed [SUM_W-1:0] e_sum;

  assign accept = start && !s1_vld;
  assign e_sum  = $signed({{(SUM_W-EXP_W){1'b0}}, dst_op[MAN_W +: EXP_W]})
                + $signed({{2{scale[SCL_W-1]}}, scale});

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_sign <= 1'b0;
      s1_exp  <= '0;
      s1_man  <= '0;
      s1_sum  <= '0;
      s1_cls  <= SRC_NUM;
      s1_rnd  <= '0;
      s1_msk  <= '0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_sign <= dst_op[OP_W-1];
        s1_exp  <= dst_op[MAN_W +: EXP_W];
        s1_man  <= dst_op[MAN_W-1:0];
        s1_sum  <= e_sum;
        s1_cls  <= src_class_e'(src_class);
        s1_rnd  <= rnd_mode;
        s1_msk  <= exc_enable;
      end
    end
  end

  assign busy = s1_vld;

  // ---------------- stage 2: path selection ----------------
  logic              dst_num;
  logic              under;
  logic              over;
  logic [SUM_W-1:0]  deficit;
  logic [MAN_W-1:0]  dr_man;
  logic              dr_carry;
  logic              dr_inex;
  logic              dr_up;
  logic [MAN_W-1:0]  ln_man;
  logic signed [SUM_W-1:0] ln_exp;

  assign dst_num = ((s1_exp != '0) && (s1_exp != EXP_MAX))
                || ((s1_exp == '0) && (s1_man != '0));
  assign under   = s1_sum < 0;
  assign over    = s1_sum >= SUM_TOP;
  assign deficit = SUM_W'(-s1_sum);

  fxs_dn_round #(.W(MAN_W), .SW(SUM_W)) u_dn_round (
    .mant     (s1_man),
    .deficit  (deficit),
    .sign     (s1_sign),
    .mode     (s1_rnd),
    .mant_out (dr_man),
    .carry    (dr_carry),
    .inexact  (dr_inex),
    .round_up (dr_up)
  );

  fxs_lnorm #(.W(MAN_W), .SW(SUM_W)) u_lnorm (
    .mant     (s1_man),
    .e_in     (s1_sum),
    .limit    (!over),
    .mant_out (ln_man),
    .e_out    (ln_exp)
  );

  logic [EXP_W-1:0] n_exp;
  logic [MAN_W-1:0] n_man;
  logic [X_W-1:0]   n_x;
  logic [C_W-1:0]   n_c;

  always_comb begin
    n_exp = s1_exp;
    n_man = s1_man;
    n_x   = '0;
    n_c   = '0;
    case (s1_cls)
      SRC_QNAN, SRC_SNAN: begin
        n_exp = EXP_MAX;
        n_man = '1;
        n_x[X_SNAN] = (s1_cls == SRC_SNAN);
      end
      SRC_INF: begin
        n_exp = EXP_MAX;
        n_man = '1;
        n_x[X_OPERR] = 1'b1;
        n_c[C_NAN]   = 1'b1;
      end
      default: begin
        if (dst_num) begin
          if (under) begin
            n_exp = {{(EXP_W-1){1'b0}}, dr_carry};
            n_man = dr_man;
            n_x[X_INEX] = dr_inex;
            if (!dr_carry && !dr_man[MAN_W-1]) begin
              n_x[X_UNFL] = 1'b1;
              n_c[C_ZERO] = (dr_man == '0);
            end
          end else if (over) begin
            if (ln_exp >= SUM_TOP) begin
              n_exp = EXP_MAX;
              n_man = '0;
              n_x[X_OVFL] = 1'b1;
              n_c[C_INF]  = 1'b1;
            end else begin
              n_exp = ln_exp[EXP_W-1:0];
              n_man = ln_man;
            end
          end else if (!s1_man[MAN_W-1]) begin
            n_exp = ln_exp[EXP_W-1:0];
            n_man = ln_man;
            n_x[X_UNFL] = !ln_man[MAN_W-1];
          end else begin
            n_exp = s1_sum[EXP_W-1:0];
          end
        end else if (s1_exp == '0) begin
          n_c[C_ZERO] = 1'b1;
        end else if (s1_man == '0) begin
          n_c[C_INF] = 1'b1;
        end else begin
          n_c[C_NAN]  = 1'b1;
          n_x[X_SNAN] = !s1_man[MAN_W-2];
        end
      end
    endcase
    n_c[C_NEG] = s1_sign;
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      result     <= '0;
      cond_flags <= '0;
      exc_flags  <= '0;
      trap       <= 1'b0;
    end else begin
      done <= s1_vld;
      if (s1_vld) begin
        result     <= {s1_sign, n_exp, n_man};
        cond_flags <= n_c;
        exc_flags  <= n_x;
        trap       <= |(n_x & s1_msk);
      end
    end
  end

  // ---------------- assertions ----------------
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_busy_then_done_r1: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy));
  p_ovfl_is_inf_r6: assert property (@(posedge clk) disable iff (rst)
    (done && exc_flags[X_OVFL]) |->
      (result[OP_W-2:0] == {EXP_MAX, {MAN_W{1'b0}}}) && cond_flags[C_INF]);
  p_unfl_exp_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (done && exc_flags[X_UNFL]) |->
      (result[MAN_W +: EXP_W] == '0) && !result[MAN_W-1]);
  p_neg_mirrors_sign_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (cond_flags[C_NEG] == result[OP_W-1]));
  p_trap_needs_exc_r12: assert property (@(posedge clk) disable iff (rst)
    (done && (exc_flags == '0)) |-> !trap);
  p_one_class_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot0(cond_flags[C_ZERO:C_NAN]));
endmodule

// File: tb/test_fx_scale_unit.sv
module test_fx_scale_unit;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [79:0] dst_op;
  logic [31:0] scale;
  logic [2:0]  src_class;
  logic [1:0]  rnd_mode;
  logic [4:0]  exc_enable;
  logic        busy, done, trap;
  logic [79:0] result;
  logic [3:0]  cond_flags;
  logic [4:0]  exc_flags;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fx_scale_unit i_fx_scale_unit (
    .clk(clk), .rst(rst), .start(start), .dst_op(dst_op), .scale(scale),
    .src_class(src_class), .rnd_mode(rnd_mode), .exc_enable(exc_enable),
    .busy(busy), .done(done), .result(result), .cond_flags(cond_flags),
    .exc_flags(exc_flags), .trap(trap)
  );

  localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e,
                                     input logic [63:0] m);
    return {s, e, m};
  endfunction

  task automatic chk(input string req, input logic [95:0] act,
                     input logic [95:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one operation and sample it when done pulses
  task automatic issue(input logic [79:0] op, input logic [31:0] sc,
                       input logic [2:0] cls, input logic [1:0] rm,
                       input logic [4:0] msk);
    @(negedge clk);
    dst_op = op; scale = sc; src_class = cls; rnd_mode = rm; exc_enable = msk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy/done after accept", {94'd0, busy, done}, {94'd0, 2'b10});
    @(negedge clk);
    chk("R1 done pulse", {95'd0, done}, 96'd1);
  endtask

  task automatic expect_out(input string req, input logic [79:0] er,
                            input logic [3:0] ec, input logic [4:0] ex,
                            input logic et);
    chk({req, " result"}, {16'd0, result}, {16'd0, er});
    chk({req, " cond"}, {92'd0, cond_flags}, {92'd0, ec});
    chk({req, " exc"}, {91'd0, exc_flags}, {91'd0, ex});
    chk({req, " trap"}, {95'd0, trap}, {95'd0, et});
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", {7'd0, busy, done, trap, cond_flags, exc_flags, result},
        96'd0);
  endtask

  task automatic t_normal;   // R2, R11
    issue(mk(0, 15'h3FFF, ONE), 32'd5, 3'd0, 2'd0, 5'h1F);
    expect_out("R2 plus five", mk(0, 15'h4004, ONE), 4'h0, 5'h00, 0);
    issue(mk(1, 15'h4000, 64'hC000_0000_0000_0000), -32'sd3, 3'd0, 2'd0, 5'h1F);
    expect_out("R2 R11 negative", mk(1, 15'h3FFD, 64'hC000_0000_0000_0000),
               4'h8, 5'h00, 0);
    issue(mk(0, 15'h3FFF, ONE), 32'h3FFF, 3'd1, 2'd0, 5'h1F);
    expect_out("R2 top in range", mk(0, 15'h7FFE, ONE), 4'h0, 5'h00, 0);
  endtask

  task automatic t_underflow;  // R3, R5
    issue(mk(0, 15'h0001, ONE), -32'sd5, 3'd0, 2'd0, 5'h00);
    expect_out("R3 R5 exact shift", mk(0, 0, 64'h0800_0000_0000_0000),
               4'h0, 5'h02, 0);
    issue(mk(0, 15'h0001, ONE), -32'sd64, 3'd0, 2'd0, 5'h00);
    expect_out("R3 deficit 63", mk(0, 0, 64'h1), 4'h0, 5'h02, 0);
    issue(mk(0, 15'h0001, ONE), -32'sd65, 3'd0, 2'd1, 5'h00);
    expect_out("R3 R5 deficit 64", mk(0, 0, 64'h0), 4'h4, 5'h03, 0);
    issue(mk(0, 15'h0002, ONE), -32'sd100, 3'd0, 2'd0, 5'h00);
    expect_out("R3 R5 deep nearest", mk(0, 0, 64'h0), 4'h4, 5'h03, 0);
    issue(mk(0, 15'h3FFF, ONE), 32'h8000_0000, 3'd0, 2'd0, 5'h00);
    expect_out("R3 most negative scale", mk(0, 0, 64'h0), 4'h4, 5'h03, 0);
  endtask

  task automatic t_rounding;  // R4, R5
    issue(mk(0, 15'h0001, 64'h8000_0000_0000_0003), -32'sd2, 3'd0, 2'd0, 5'h00);
    expect_out("R4 tie odd nearest", mk(0, 0, 64'h4000_0000_0000_0002),
               4'h0, 5'h03, 0);
    issue(mk(0, 15'h0001, 64'h8000_0000_0000_0001), -32'sd2, 3'd0, 2'd0, 5'h00);
    expect_out("R4 tie even nearest", mk(0, 0, 64'h4000_0000_0000_0000),
               4'h0, 5'h03, 0);
    issue(mk(0, 15'h0001, 64'h8000_0000_0000_0003), -32'sd3, 3'd0, 2'd0, 5'h00);
    expect_out("R4 above half", mk(0, 0, 64'h2000_0000_0000_0001),
               4'h0, 5'h03, 0);
    issue(mk(0, 15'h0001, 64'h8000_0000_0000_0003), -32'sd2, 3'd0, 2'd1, 5'h00);
    expect_out("R4 toward zero", mk(0, 0, 64'h4000_0000_0000_0001),
               4'h0, 5'h03, 0);
    issue(mk(0, 15'h0001, 64'h8000_0000_0000_0003), -32'sd2, 3'd0, 2'd2, 5'h00);
    expect_out("R4 down positive", mk(0, 0, 64'h4000_0000_0000_0001),
               4'h0, 5'h03, 0);
    issue(mk(1, 15'h0001, 64'h8000_0000_0000_0003), -32'sd2, 3'd0, 2'd2, 5'h00);
    expect_out("R4 down negative", mk(1, 0, 64'h4000_0000_0000_0002),
               4'h8, 5'h03, 0);
    issue(mk(0, 15'h0001, 64'h8000_0000_0000_0003), -32'sd2, 3'd0, 2'd3, 5'h00);
    expect_out("R4 up positive", mk(0, 0, 64'h4000_0000_0000_0002),
               4'h0, 5'h03, 0);
    issue(mk(0, 15'h0002, ONE), -32'sd100, 3'd0, 2'd3, 5'h00);
    expect_out("R4 up from all sticky", mk(0, 0, 64'h1), 4'h0, 5'h03, 0);
    issue(mk(0, 15'h0001, 64'hFFFF_FFFF_FFFF_FFFF), -32'sd2, 3'd0, 2'd0, 5'h00);
    expect_out("R4 R5 round into integer bit", mk(0, 0, ONE), 4'h0, 5'h01, 0);
  endtask

  task automatic t_overflow;  // R6
    issue(mk(0, 15'h7FFE, ONE), 32'd1, 3'd0, 2'd0, 5'h04);
    expect_out("R6 overflow trap", mk(0, 15'h7FFF, 64'h0), 4'h2, 5'h04, 1);
    issue(mk(0, 15'h7FF0, 64'h0000_0001_0000_0000), 32'h10, 3'd0, 2'd0, 5'h00);
    expect_out("R6 unnormal rescued", mk(0, 15'h7FE1, ONE), 4'h0, 5'h00, 0);
    issue(mk(1, 15'h3FFF, ONE), 32'h7FFF_FFFF, 3'd0, 2'd0, 5'h00);
    expect_out("R6 largest scale", mk(1, 15'h7FFF, 64'h0), 4'hA, 5'h04, 0);
  endtask

  task automatic t_denormal;  // R7
    issue(mk(0, 15'h0000, 64'h10), 32'd100, 3'd0, 2'd0, 5'h00);
    expect_out("R7 full normalize", mk(0, 15'h0029, ONE), 4'h0, 5'h00, 0);
    issue(mk(0, 15'h0000, 64'h10), 32'd10, 3'd0, 2'd0, 5'h00);
    expect_out("R7 limited shift", mk(0, 0, 64'h4000), 4'h0, 5'h02, 0);
    issue(mk(0, 15'h0000, 64'h10), 32'd0, 3'd0, 2'd0, 5'h00);
    expect_out("R7 zero scale", mk(0, 0, 64'h10), 4'h0, 5'h02, 0);
  endtask

  task automatic t_src_special;  // R8, R9
    issue(mk(1, 15'h3FFF, ONE), 32'd3, 3'd3, 2'd0, 5'h1F);
    expect_out("R8 quiet source", mk(1, 15'h7FFF, '1), 4'h8, 5'h00, 0);
    issue(mk(0, 15'h3FFF, ONE), 32'd3, 3'd4, 2'd0, 5'h10);
    expect_out("R8 signaling source", mk(0, 15'h7FFF, '1), 4'h0, 5'h10, 1);
    issue(mk(0, 15'h3FFF, ONE), 32'd3, 3'd2, 2'd0, 5'h00);
    expect_out("R9 infinite source", mk(0, 15'h7FFF, '1), 4'h1, 5'h08, 0);
  endtask

  task automatic t_dst_special;  // R10, R11
    issue(mk(0, 0, 64'h0), 32'd5, 3'd0, 2'd0, 5'h00);
    expect_out("R10 zero dest", mk(0, 0, 64'h0), 4'h4, 5'h00, 0);
    issue(mk(1, 15'h7FFF, 64'h0), 32'd5, 3'd0, 2'd0, 5'h00);
    expect_out("R10 R11 inf dest", mk(1, 15'h7FFF, 64'h0), 4'hA, 5'h00, 0);
    issue(mk(0, 15'h7FFF, 64'hC000_0000_0000_0000), 32'd5, 3'd0, 2'd0, 5'h1F);
    expect_out("R10 quiet dest", mk(0, 15'h7FFF, 64'hC000_0000_0000_0000),
               4'h1, 5'h00, 0);
    issue(mk(0, 15'h7FFF, 64'h8000_0000_0000_0001), 32'd5, 3'd0, 2'd0, 5'h00);
    expect_out("R10 signaling dest", mk(0, 15'h7FFF, 64'h8000_0000_0000_0001),
               4'h1, 5'h10, 0);
  endtask

  task automatic t_trap;  // R12
    issue(mk(0, 15'h0001, ONE), -32'sd5, 3'd0, 2'd0, 5'h05);
    expect_out("R12 mask misses", mk(0, 0, 64'h0800_0000_0000_0000), 4'h0, 5'h02, 0);
    issue(mk(0, 15'h0001, ONE), -32'sd5, 3'd0, 2'd0, 5'h02);
    expect_out("R12 mask hits", mk(0, 0, 64'h0800_0000_0000_0000), 4'h0, 5'h02, 1);
  endtask

  task automatic t_busy_ignore;  // R1
    @(negedge clk);
    dst_op = mk(0, 15'h3FFF, ONE); scale = 32'd1; src_class = 3'd0;
    rnd_mode = 2'd0; exc_enable = 5'h00; start = 1'b1;
    @(negedge clk);
    dst_op = mk(1, 15'h1234, ONE); scale = 32'd7;   // start held while busy
    chk("R1 busy holds", {95'd0, busy}, 96'd1);
    @(negedge clk);
    start = 1'b0;
    chk("R1 first result only", {15'd0, done, result},
        {15'd0, 1'b1, mk(0, 15'h4000, ONE)});
    @(negedge clk);
    chk("R1 no second op", {94'd0, busy, done}, 96'd0);
    chk("R1 result held", {16'd0, result}, {16'd0, mk(0, 15'h4000, ONE)});
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; dst_op = '0; scale = '0;
    src_class = '0; rnd_mode = '0; exc_enable = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_underflow();
    t_rounding();
    t_overflow();
    t_denormal();
    t_src_special();
    t_dst_special();
    t_trap();
    t_busy_ignore();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule